// File: doc/BRIEF.md
# Majority-Vote Byte-Lane Sampler

This block reduces repeated reads of a memory-training status word to one decision bit per byte lane. After a start pulse it asks an upstream test-traffic source for status words, one per request/acknowledge handshake. Each word carries two lanes of one lane group. The block counts how many reads show a 1 for each lane and keeps the majority as that lane's result. It covers every active lane group in turn, reports the whole result vector with a one-cycle completion pulse, and then goes back to idle.

The same sampler serves both receive-enable training and write-strobe training. The two modes read each lane at different status bit positions. A channel-width input selects full width, where all lane groups are sampled, or x16, where only the lower half of the groups is sampled. The first traffic request of each run is flagged so the traffic source can perform its one-time setup.

Top module: `lane_vote_sampler`

## Requirements
- R1: While reset is high and after it is released, `req_o`, `first_o` and `done_o` are 0 and `lanes_o` is all zeros.
- R2: A `start_i` pulse while idle begins a run and `req_o` goes high in the next cycle. `req_o` stays high until the run's last handshake. A `start_i` received during a run has no effect on the handshake count or the result.
- R3: Each handshake is a cycle with `req_o` and `ack_i` both high. Each active lane group takes exactly SAMPLES handshakes (default 3). Groups are visited in ascending order, and `group_o` shows the index of the group being sampled.
- R4: `first_o` is high only while the first handshake of a run is pending, and it is low for every later handshake of that run.
- R5: In receive-enable mode (`wstrobe_mode_i`=0), the even lane of a group is read from status bit 1 and the odd lane from status bit 0.
- R6: In write-strobe mode (`wstrobe_mode_i`=1), the even lane is read from status bit 9 and the odd lane from status bit 8. In both modes, all other status bits are ignored.
- R7: A lane's result is 1 exactly when more of its samples read 1 than 0. Otherwise it is 0.
- R8: The result of lane l (0 or 1) of group g is placed at `lanes_o` bit l + 2*g.
- R9: With `x16_i`=1, only the lower GROUPS/2 groups are sampled, and the result bits of the unsampled lanes are 0.
- R10: `done_o` is high for exactly one cycle, in the cycle after the last handshake. `lanes_o` is valid from that cycle on and is held until the next run starts.
- R11: The lane tallies restart at zero for every group, so one group's samples never affect another group's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| wstrobe_mode_i | input | 1 | 0 selects receive-enable bit positions, 1 selects write-strobe positions |
| x16_i | input | 1 | 1 selects half-width channel (half the lane groups) |
| req_o | output | 1 | Sample request to the traffic source |
| first_o | output | 1 | Marks the first request of a run |
| ack_i | input | 1 | Handshake acknowledge; `status_i` is valid with it |
| group_o | output | GRP_W | Lane group being sampled |
| status_i | input | 16 | Training status word |
| done_o | output | 1 | One-cycle completion pulse |
| lanes_o | output | 2*GROUPS | Per-lane majority result |

## Verification
The embedded assertions check on every cycle that:
- `first_o` only occurs with a pending request and clears after the first handshake;
- the completion pulse is single-cycle and never overlaps a request;
- no tally runs past the sample count;
- x16 runs never address an upper group or report upper lanes;
- the result holds while idle.

Only the bench's scenarios can show the values themselves. It sweeps every 3-sample pattern on each lane in both modes and both widths. It fills the unused status bits with noise, inserts acknowledge gaps, and sends a start during a run. It then compares bit placement, the majority result and the handshake counts against values computed from the requirements.

// File: rtl/lvs_pkg.sv
package lvs_pkg;

    localparam int STAT_W = 16;

    // status bit positions per training mode (even lane / odd lane)
    localparam int RX_EVEN_BIT = 1;
    localparam int RX_ODD_BIT  = 0;
    localparam int WS_EVEN_BIT = 9;
    localparam int WS_ODD_BIT  = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } lvs_state_e;

    typedef struct packed {
        logic wstrobe;
        logic x16;
    } lvs_cfg_t;

    // returns {odd lane, even lane} from one status word
    function automatic logic [1:0] lvs_pick(input logic ws, input logic [STAT_W-1:0] w);
        return ws ? {w[WS_ODD_BIT], w[WS_EVEN_BIT]} : {w[RX_ODD_BIT], w[RX_EVEN_BIT]};
    endfunction

endpackage

// File: rtl/lvs_tally.sv
module lvs_tally #(
    parameter int SAMPLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic take_i,
    input  logic bit_i,
    output logic vote_o
);
    localparam int CNT_W = $clog2(SAMPLES + 1);

    logic [CNT_W-1:0] ones_q;
    logic [CNT_W:0]   with_cur;

    // vote includes the sample being taken this cycle
    always_comb begin
        with_cur = {1'b0, ones_q} + {{CNT_W{1'b0}}, (take_i & bit_i)};
        vote_o   = (32'(with_cur) * 2) > SAMPLES;
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            ones_q <= '0;
        end else if (take_i && bit_i) begin
            ones_q <= ones_q + 1'b1;
        end
    end

    // R7: a tally can never exceed the number of samples per group
    p_tally_bound_r7: assert property (@(posedge clk) disable iff (rst)
        32'(ones_q) <= SAMPLES);

endmodule

// File: rtl/lvs_ctrl.sv
module lvs_ctrl
    import lvs_pkg::*;
#(
    parameter int GROUPS  = 2,
    parameter int SAMPLES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  lvs_cfg_t         cfg_i,
    input  logic             ack_i,
    output logic             req_o,
    output logic             first_o,
    output logic             done_o,
    output logic             idle_o,
    output logic             launch_o,
    output logic             take_o,
    output logic             close_o,
    output logic [(GROUPS > 1 ? $clog2(GROUPS) : 1)-1:0] group_o,
    output lvs_cfg_t         cfg_o
);
    localparam int GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam int SMP_W = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;
    localparam logic [SMP_W-1:0] SMP_LAST  = SMP_W'(SAMPLES - 1);
    localparam logic [GRP_W-1:0] GRP_LAST  = GRP_W'(GROUPS - 1);
    localparam logic [GRP_W-1:0] GRP_LASTH = GRP_W'(GROUPS / 2 - 1);

    lvs_state_e       state_q;
    logic [SMP_W-1:0] smp_q;
    logic [GRP_W-1:0] grp_q;
    logic             first_q;
    lvs_cfg_t         cfg_q;
    logic [GRP_W-1:0] grp_end;

    always_comb begin
        grp_end  = cfg_q.x16 ? GRP_LASTH : GRP_LAST;
        req_o    = (state_q == ST_RUN);
        done_o   = (state_q == ST_DONE);
        idle_o   = (state_q == ST_IDLE);
        launch_o = idle_o && start_i;
        take_o   = req_o && ack_i;
        close_o  = take_o && (smp_q == SMP_LAST);
        first_o  = req_o && first_q;
        group_o  = grp_q;
        cfg_o    = cfg_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            smp_q   <= '0;
            grp_q   <= '0;
            first_q <= 1'b0;
            cfg_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    state_q <= ST_RUN;
                    smp_q   <= '0;
                    grp_q   <= '0;
                    first_q <= 1'b1;
                    cfg_q   <= cfg_i;
                end
                ST_RUN: if (ack_i) begin
                    first_q <= 1'b0;
                    if (smp_q == SMP_LAST) begin
                        smp_q <= '0;
                        if (grp_q == grp_end) state_q <= ST_DONE;
                        else                  grp_q   <= grp_q + 1'b1;
                    end else begin
                        smp_q <= smp_q + 1'b1;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R4: first flag only accompanies a pending request
    p_first_with_req_r4: assert property (@(posedge clk) disable iff (rst)
        first_o |-> req_o);
    // R4: once a handshake is taken the first flag is gone
    p_first_once_r4: assert property (@(posedge clk) disable iff (rst)
        (req_o && ack_i) |=> !first_o);
    // R10: completion is a single-cycle pulse without a request
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    p_done_no_req_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !req_o);
    // R9: half-width runs stay in the lower groups
    p_x16_range_r9: assert property (@(posedge clk) disable iff (rst)
        (req_o && cfg_q.x16) |-> (group_o <= GRP_LASTH));

endmodule

// File: rtl/lane_vote_sampler.sv
module lane_vote_sampler
    import lvs_pkg::*;
#(
    parameter int GROUPS  = 2,
    parameter int SAMPLES = 3,
    parameter int GRP_W   = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    parameter int LANES   = 2 * GROUPS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              wstrobe_mode_i,
    input  logic              x16_i,
    output logic              req_o,
    output logic              first_o,
    input  logic              ack_i,
    output logic [GRP_W-1:0]  group_o,
    input  logic [STAT_W-1:0] status_i,
    output logic              done_o,
    output logic [LANES-1:0]  lanes_o
);
    localparam int HALF = LANES / 2;

    lvs_cfg_t   cfg_in, cfg_q;
    logic       idle, launch, take, close;
    logic [1:0] picked, votes;
    logic [LANES-1:0] res_q, res_d;

    assign cfg_in = '{wstrobe: wstrobe_mode_i, x16: x16_i};

    lvs_ctrl #(.GROUPS(GROUPS), .SAMPLES(SAMPLES)) u_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .cfg_i(cfg_in), .ack_i(ack_i),
        .req_o(req_o), .first_o(first_o), .done_o(done_o), .idle_o(idle),
        .launch_o(launch), .take_o(take), .close_o(close),
        .group_o(group_o), .cfg_o(cfg_q)
    );

    assign picked = lvs_pick(cfg_q.wstrobe, status_i);

    for (genvar l = 0; l < 2; l++) begin : g_lane
        lvs_tally #(.SAMPLES(SAMPLES)) u_tally (
            .clk(clk), .rst(rst),
            .clear_i(launch || close),
            .take_i(take), .bit_i(picked[l]),
            .vote_o(votes[l])
        );
    end

    always_comb begin
        res_d = res_q;
        if (launch) begin
            res_d = '0;
        end else if (close) begin
            for (int g = 0; g < GROUPS; g++) begin
                if (group_o == GRP_W'(g)) res_d[2*g +: 2] = votes;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign lanes_o = res_q;

    // R9: unsampled upper lanes read 0 when a half-width run completes
    p_x16_upper_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (done_o && cfg_q.x16) |-> (lanes_o[LANES-1:HALF] == '0));
    // R10: result is held while idle and not restarted
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (idle && !start_i) |=> $stable(lanes_o));

endmodule

// File: tb/sim_lane_vote_sampler.sv
`timescale 1ns/1ps
module sim_lane_vote_sampler;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, ws_i = 1'b0, x16_i = 1'b0, ack_i = 1'b0;
    logic req_o, first_o, done_o;
    logic [0:0]  group_o;
    logic [15:0] status_i = '0;
    logic [3:0]  lanes_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    lane_vote_sampler u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .wstrobe_mode_i(ws_i),
        .x16_i(x16_i), .req_o(req_o), .first_o(first_o), .ack_i(ack_i),
        .group_o(group_o), .status_i(status_i), .done_o(done_o), .lanes_o(lanes_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // 3-sample pattern of lane l in group g for sweep index p
    function automatic logic [2:0] pat(input int g, input int l, input int p);
        int v;
        v = (g == 0) ? p : ((p * 37) % 64);
        return l ? 3'(v >> 3) : 3'(v);
    endfunction

    function automatic logic [15:0] word(input bit ws, input bit b0, input bit b1, input int k);
        logic [15:0] n;
        n = 16'h5A3C ^ 16'(k * 16'h1357);
        if (ws) begin n[9] = b0; n[8] = b1; end   // R6 positions
        else    begin n[1] = b0; n[0] = b1; end   // R5 positions
        return n;
    endfunction

    task automatic run(input bit ws, input bit nar, input int p, input bit poke);
        int ng, k, t, last_t;
        bit seen;
        logic [3:0] exp;
        ng = nar ? 1 : 2;
        exp = '0;
        for (int g = 0; g < ng; g++)
            for (int l = 0; l < 2; l++)
                exp[l + 2*g] = ($countones(pat(g, l, p)) > 1);  // R7 R8
        k = 0; t = 0; last_t = -10; seen = 0;
        @(negedge clk);
        start_i = 1'b1; ws_i = ws; x16_i = nar;
        @(negedge clk);
        start_i = 1'b0;
        chk(req_o == 1'b1, "R2 req after start", req_o, 1);
        while (!seen && t < 200) begin
            ack_i = 1'b0;
            start_i = 1'b0;
            if (done_o) begin
                seen = 1;
            end else if (req_o) begin
                if (poke && k == 2) start_i = 1'b1;  // R2 ignored during run
                if (((k + p + t) % 5) != 4) begin
                    chk(group_o == 1'(k / 3), "R3 group order", group_o, k / 3);
                    chk(first_o == (k == 0), "R4 first flag", first_o, k == 0);
                    status_i = word(ws, pat(k/3, 0, p)[k%3], pat(k/3, 1, p)[k%3], k);
                    ack_i = 1'b1;
                    k++;
                    last_t = t;
                end else begin
                    status_i = ~status_i;  // noise while no handshake
                end
            end
            if (!seen) begin
                @(negedge clk);
                t++;
            end
        end
        ack_i = 1'b0;
        start_i = 1'b0;
        chk(seen, "R10 done seen (watchdog)", seen, 1);
        chk(t == last_t + 1, "R10 done timing", t, last_t + 1);
        chk(k == ng * 3, "R3 R9 handshake count", k, ng * 3);
        chk(lanes_o == exp, ws ? "R6 R7 R8 R9 R11 result" : "R5 R7 R8 R9 R11 result",
            lanes_o, exp);
        @(negedge clk);
        chk(done_o == 1'b0 && req_o == 1'b0, "R10 single pulse", done_o, 0);
        @(negedge clk);
        chk(lanes_o == exp, "R10 result held", lanes_o, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_o == 0 && done_o == 0 && first_o == 0 && lanes_o == 0,
            "R1 during reset", {req_o, done_o, first_o, lanes_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_o == 0 && done_o == 0 && lanes_o == 0, "R1 after reset",
            {req_o, done_o, lanes_o}, 0);
        for (int ws = 0; ws < 2; ws++)
            for (int nar = 0; nar < 2; nar++)
                for (int p = 0; p < 64; p++)
                    run(ws[0], nar[0], p, (p % 16) == 5);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule